// File: doc/BRIEF.md
# DRAM refresh and power-up sequencer

This block takes over every refresh obligation of an asynchronous multiplexed-address DRAM. After reset is released it holds off for a parameterised power-up pause. It then runs a fixed number of initialisation cycles, and each of these is itself a refresh cycle. From then on an interval timer adds one owed refresh per period. The period is chosen so that all rows are refreshed within the retention time: about 3900 cycles of 4 ns for 4096 rows in 64 ms.

The block does not own the memory bus. It raises a request and waits for the access controller to grant the bus. While the grant is held it drives the row strobe, the column strobe and the write strobe by itself. A parameter selects one of two refresh styles. In the first, the column strobe falls ahead of the row strobe, so the device's internal row counter is used and the address bus is ignored. In the second, the column strobe stays high and the block drives a row address from its own wrapping counter. When owed refreshes pile up to a set limit, an urgent flag asks the controller to close its open row at once.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is held, and on the first sample after release, `ras_n`, `cas_n` and `we_n` are high, and `busy`, `rfsh_req`, `rfsh_urgent` and `init_done` are low.
- R2: For `PAUSE_CYC` cycles after reset release, no request is raised and no strobe moves, even with the grant high.
- R3: After the pause, exactly `INIT_CYC` refresh cycles are run through request and grant. `init_done` rises at the clock edge that ends the precharge of the last of them and never falls afterwards.
- R4: Once `init_done` is high, one refresh becomes owed every `REFI_CYC` cycles. The first becomes owed `REFI_CYC` cycles after `init_done` rises. `rfsh_req` is high while any refresh is owed.
- R5: The owed count saturates at `PEND_MAX`. `rfsh_urgent` is high exactly when the count is at that limit. A granted burst runs exactly as many cycles as are owed.
- R6: Every refresh holds `ras_n` low for exactly `T_RAS` cycles. Between two refreshes `ras_n` stays high for at least `T_RP` cycles.
- R7: In column-first mode (`RAS_ONLY`=0), `cas_n` is low for at least `T_LEAD` cycles before each fall of `ras_n` and stays low for the whole time `ras_n` is low. `row_addr` is held at zero.
- R8: In column-first mode, when a refresh is owed and the grant is still high at the end of a precharge, the next `ras_n` fall follows with `cas_n` kept low. A burst of any length therefore shows a single rise of `cas_n`.
- R9: In row-address mode (`RAS_ONLY`=1), `cas_n` never goes low. `row_addr` is stable while `ras_n` is low. `row_addr` advances by one, modulo 2^`ROW_W`, at the edge where `ras_n` rises, so consecutive refreshes use rows 0, 1, 2 and so on, and row 4095 is followed by row 0.
- R10: `we_n` stays high at all times.
- R11: No refresh cycle starts while `bus_grant` is low. Owed refreshes wait and do not strobe the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (4 ns period in the default timing) |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_grant | input | 1 | Access controller hands the DRAM bus to this block |
| rfsh_req | output | 1 | Refresh or initialisation cycle owed |
| rfsh_urgent | output | 1 | Owed count at its limit; the controller must close its row now |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, always high |
| row_addr | output | ROW_W | Row to refresh in row-address mode, zero otherwise |
| busy | output | 1 | A strobe sequence is in progress |
| init_done | output | 1 | Pause and all initialisation cycles are complete |

## Verification
The bench holds the grant high during the pause. A design that counted the pause short, or ignored it, would strobe early. It counts the row strobes exactly up to the rise of `init_done`, which catches a design that reports completion a cycle early or runs a ninth initialisation cycle. It lets several intervals pass with the grant low, including more than the limit. A counter that wraps instead of saturating, or an urgent flag one off, then shows up as a wrong burst length or a wrong flag. Checks on the interval phase and on the number of column-strobe rises per burst catch a drifting timer and a design that drops `cas_n` between chained refreshes. A row-address instance is run through more than 4096 refreshes to check that the row counter wraps.

// File: rtl/dram_rfsh_pkg.sv
// Shared types for the DRAM refresh sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dram_rfsh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // bus not driven by this block
        ST_LEAD = 2'd1,   // column-strobe lead or row-address setup
        ST_ACT  = 2'd2,   // row strobe low
        ST_PRE  = 2'd3    // row strobe precharge
    } strobe_st_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/rfsh_powerup_ctl.sv
// Power-up pause and initialisation-cycle bookkeeping.
// Counts PAUSE_CYC cycles after reset, then owes INIT_CYC refresh cycles.
// Assumes: take pulses once per started cycle, cycle_done once per finished one.
module rfsh_powerup_ctl #(
    parameter int PAUSE_CYC = 50000,
    parameter int INIT_CYC  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic cycle_done,
    output logic pause_done,
    output logic init_owed,
    output logic init_done
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int IW = $clog2(INIT_CYC + 1);

    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] init_left;

    // Pause timer: runs once after reset and then holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_cnt  <= '0;
            pause_done <= 1'b0;
        end else if (!pause_done) begin
            if (pause_cnt == PW'(PAUSE_CYC - 1)) pause_done <= 1'b1;
            else                                  pause_cnt  <= pause_cnt + 1'b1;
        end
    end

    // Initialisation cycles still to start.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          init_left <= IW'(INIT_CYC);
        else if (take && pause_done && init_left != '0)      init_left <= init_left - 1'b1;
    end

    // Done flag: set when the last initialisation cycle finishes its precharge.
    always_ff @(posedge clk) begin
        if (!rst_n)                                               init_done <= 1'b0;
        else if (cycle_done && pause_done && init_left == '0)     init_done <= 1'b1;
    end

    assign init_owed = pause_done && (init_left != '0);

    // R3
    init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(init_done));
    // R3
    init_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(cycle_done));
endmodule

// File: rtl/rfsh_rate_tracker.sv
// Interval timer and saturating owed-refresh counter.
// Adds one owed refresh every REFI_CYC cycles once enabled.
// Assumes: take only pulses while a refresh is owed.
module rfsh_rate_tracker #(
    parameter int REFI_CYC = 3900,
    parameter int PEND_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic take,
    output logic owed,
    output logic urgent
);
    localparam int TW = $clog2(REFI_CYC + 1);
    localparam int CW = $clog2(PEND_MAX + 1);

    logic [TW-1:0] timer;
    logic [CW-1:0] pending;
    logic          tick;
    logic          take_eff;

    assign tick     = enable && (timer == TW'(REFI_CYC - 1));
    assign take_eff = enable && take;

    // Free-running interval timer, held at zero until enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) timer <= '0;
        else if (tick)         timer <= '0;
        else                   timer <= timer + 1'b1;
    end

    // Owed count: up on a tick, down on a take, saturating at PEND_MAX.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else if (tick && !take_eff) begin
            if (pending != CW'(PEND_MAX)) pending <= pending + 1'b1;
        end else if (take_eff && !tick) begin
            if (pending != '0) pending <= pending - 1'b1;
        end
    end

    assign owed   = (pending != '0);
    assign urgent = (pending == CW'(PEND_MAX));

    // R5
    pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= CW'(PEND_MAX));
    // R4
    pend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> pending == '0);
endmodule

// File: rtl/rfsh_strobe_fsm.sv
// Strobe engine: drives the row, column and write strobes for one refresh.
// Column-first mode chains refreshes with the column strobe held low.
// Row-address mode keeps the column strobe high and steps a row counter.
// Assumes: T_LEAD, T_RAS and T_RP are at least 1.
module rfsh_strobe_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int RAS_ONLY = 0,
    parameter int ROW_W    = 12,
    parameter int T_LEAD   = 2,
    parameter int T_RAS    = 15,
    parameter int T_RP     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want,
    input  logic             grant,
    output logic             take,
    output logic             cycle_done,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             busy
);
    localparam int TMAX = max3(T_LEAD, T_RAS, T_RP);
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] LEAD_END = CW'(T_LEAD - 1);
    localparam logic [CW-1:0] ACT_END  = CW'(T_RAS - 1);
    localparam logic [CW-1:0] PRE_END  = CW'(T_RP - 1);

    strobe_st_e    st, nxt_st;
    logic [CW-1:0] cnt, nxt_cnt;
    logic          start_idle, pre_last, chain, act_last;

    assign start_idle = (st == ST_IDLE) && want && grant;
    assign pre_last   = (st == ST_PRE) && (cnt == PRE_END);
    assign act_last   = (st == ST_ACT) && (cnt == ACT_END);
    assign chain      = (RAS_ONLY == 0) && pre_last && want && grant;
    assign take       = start_idle || chain;
    assign cycle_done = pre_last;
    assign busy       = (st != ST_IDLE);

    // Next-state and phase-counter logic.
    always_comb begin
        nxt_st  = st;
        nxt_cnt = cnt + 1'b1;
        case (st)
            ST_IDLE: begin
                nxt_cnt = '0;
                if (start_idle) nxt_st = ST_LEAD;
            end
            ST_LEAD: if (cnt == LEAD_END) begin nxt_st = ST_ACT; nxt_cnt = '0; end
            ST_ACT:  if (act_last)        begin nxt_st = ST_PRE; nxt_cnt = '0; end
            ST_PRE:  if (pre_last) begin
                nxt_st  = chain ? ST_ACT : ST_IDLE;
                nxt_cnt = '0;
            end
            default: begin nxt_st = ST_IDLE; nxt_cnt = '0; end
        endcase
    end

    // State, counter and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
        end else begin
            st    <= nxt_st;
            cnt   <= nxt_cnt;
            ras_n <= (nxt_st != ST_ACT);
            cas_n <= (RAS_ONLY != 0) ? 1'b1 : (nxt_st == ST_IDLE);
        end
    end

    generate
        if (RAS_ONLY != 0) begin : g_row_ctr
            logic [ROW_W-1:0] row_q;
            // Row counter: steps when the row strobe is released.
            always_ff @(posedge clk) begin
                if (!rst_n)        row_q <= '0;
                else if (act_last) row_q <= row_q + 1'b1;
            end
            assign row_addr = row_q;

            // R9
            row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ras_n && $past(!ras_n)) |-> $stable(row_addr));
            // R9
            row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ras_n) |-> row_addr == $past(row_addr) + 1'b1);
            // R9
            cas_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cas_n);
        end else begin : g_no_row
            assign row_addr = '0;

            // R7
            cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n) |-> $past(!cas_n));
            // R7
            cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ras_n && $past(!ras_n)) |-> !cas_n);
        end
    endgenerate
endmodule

// File: rtl/dram_rfsh_seq.sv
// Top of the DRAM refresh and power-up sequencer.
// Joins the pause and initialisation control, the refresh-rate tracker
// and the strobe engine. Requests the bus and strobes it while granted.
// Assumes: the access controller releases the DRAM pins while bus_grant is high.
module dram_rfsh_seq #(
    parameter int RAS_ONLY  = 0,
    parameter int ROW_W     = 12,
    parameter int PAUSE_CYC = 50000,
    parameter int INIT_CYC  = 8,
    parameter int REFI_CYC  = 3900,
    parameter int PEND_MAX  = 4,
    parameter int T_LEAD    = 2,
    parameter int T_RAS     = 15,
    parameter int T_RP      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_grant,
    output logic             rfsh_req,
    output logic             rfsh_urgent,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             busy,
    output logic             init_done
);
    logic pause_done, init_owed, rate_owed, rate_urgent, take, cycle_done;

    rfsh_powerup_ctl #(.PAUSE_CYC(PAUSE_CYC), .INIT_CYC(INIT_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n), .take(take), .cycle_done(cycle_done),
        .pause_done(pause_done), .init_owed(init_owed), .init_done(init_done)
    );

    rfsh_rate_tracker #(.REFI_CYC(REFI_CYC), .PEND_MAX(PEND_MAX)) u_rate (
        .clk(clk), .rst_n(rst_n), .enable(init_done), .take(take),
        .owed(rate_owed), .urgent(rate_urgent)
    );

    rfsh_strobe_fsm #(.RAS_ONLY(RAS_ONLY), .ROW_W(ROW_W), .T_LEAD(T_LEAD),
                      .T_RAS(T_RAS), .T_RP(T_RP)) u_strb (
        .clk(clk), .rst_n(rst_n), .want(rfsh_req), .grant(bus_grant),
        .take(take), .cycle_done(cycle_done), .ras_n(ras_n), .cas_n(cas_n),
        .row_addr(row_addr), .busy(busy)
    );

    assign rfsh_req    = init_owed || (init_done && rate_owed);
    assign rfsh_urgent = init_done && rate_urgent;
    assign we_n        = 1'b1;

    // R2
    pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_done |-> (ras_n && !busy));
    // R11
    no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !bus_grant) |=> !busy);
    // R5
    urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_urgent |-> rfsh_req);
endmodule

// File: tb/sim_dram_rfsh_seq.sv
`timescale 1ns/1ps
module sim_dram_rfsh_seq;
    localparam int PAUSE0 = 40, INIT0 = 8, REFI0 = 100, PMAX0 = 3;
    localparam int TL = 2, TR = 4, TP = 3;
    localparam int PAUSE1 = 20, REFI1 = 5;
    localparam int NVEC = 6;
    // {intervals left with grant low, expected urgent, expected burst length}
    localparam int VEC [NVEC][3] = '{'{1,0,1}, '{2,0,2}, '{3,1,3},
                                     '{5,1,3}, '{4,1,3}, '{2,0,2}};

    logic clk = 1'b0, rst_n = 1'b0, g0 = 1'b0, g1 = 1'b0;
    logic req0, urg0, ras0, cas0, we0, busy0, done0;
    logic req1, urg1, ras1, cas1, we1, busy1, done1;
    logic [11:0] row0, row1;
    int total = 0, bad = 0, cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_rfsh_seq #(.RAS_ONLY(0), .PAUSE_CYC(PAUSE0), .INIT_CYC(INIT0), .REFI_CYC(REFI0),
        .PEND_MAX(PMAX0), .T_LEAD(TL), .T_RAS(TR), .T_RP(TP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_grant(g0), .rfsh_req(req0), .rfsh_urgent(urg0),
        .ras_n(ras0), .cas_n(cas0), .we_n(we0), .row_addr(row0), .busy(busy0),
        .init_done(done0));

    dram_rfsh_seq #(.RAS_ONLY(1), .PAUSE_CYC(PAUSE1), .INIT_CYC(INIT0), .REFI_CYC(REFI1),
        .PEND_MAX(PMAX0), .T_LEAD(TL), .T_RAS(TR), .T_RP(TP)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_grant(g1), .rfsh_req(req1), .rfsh_urgent(urg1),
        .ras_n(ras1), .cas_n(cas1), .we_n(we1), .row_addr(row1), .busy(busy1),
        .init_done(done1));

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Strobe monitor for the column-first instance.
    int falls0 = 0, casr0 = 0, v_lead0 = 0, v_hold0 = 0, v_ras0 = 0, v_rp0 = 0, v_we = 0, v_row0 = 0;
    int clo0 = 0, rlo0 = 0, rhi0 = 0;
    logic pras0 = 1'b1, pcas0 = 1'b1;
    always @(negedge clk) if (rst_n) begin
        if (pras0 && !ras0) begin
            falls0++;
            if (clo0 < TL) v_lead0++;
            if (falls0 > 1 && rhi0 < TP) v_rp0++;
            rhi0 = 0;
        end
        if (!pras0 && ras0) begin
            if (rlo0 != TR) v_ras0++;
            rlo0 = 0;
        end
        if (!ras0) begin rlo0++; if (cas0) v_hold0++; end
        else rhi0++;
        if (!pcas0 && cas0) casr0++;
        clo0 = cas0 ? 0 : clo0 + 1;
        if (!we0 || !we1) v_we++;
        if (row0 != 12'd0) v_row0++;
        pras0 = ras0; pcas0 = cas0;
    end

    // Strobe monitor for the row-address instance.
    int falls1 = 0, wraps1 = 0, v_cas1 = 0, v_row1 = 0, v_ras1 = 0, v_rp1 = 0;
    int rlo1 = 0, rhi1 = 0;
    logic [11:0] exp_row = 12'd0;
    logic pras1 = 1'b1;
    always @(negedge clk) if (rst_n) begin
        if (pras1 && !ras1) begin
            if (row1 != exp_row) v_row1++;
            if (falls1 > 0 && row1 == 12'd0) wraps1++;
            if (falls1 > 0 && rhi1 < TP) v_rp1++;
            exp_row = exp_row + 12'd1;
            falls1++;
            rhi1 = 0;
        end
        if (!pras1 && ras1) begin
            if (rlo1 != TR) v_ras1++;
            rlo1 = 0;
        end
        if (!ras1) rlo1++; else rhi1++;
        if (!cas1) v_cas1++;
        pras1 = ras1;
    end

    task automatic wait_req0(output int t_rise);
        int n = 0;
        while (!req0 && n < 3 * REFI0) begin @(negedge clk); n++; end
        t_rise = cyc;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t_init, t_first, t_rise, snap_f, snap_c, n;
        repeat (3) @(negedge clk);
        // R1: reset state on both instances
        chk(ras0 && cas0 && we0 && !busy0 && !req0 && !urg0 && !done0, "R1 u0 reset",
            {ras0, cas0, we0, busy0, req0, urg0, done0}, 7'b1110000);
        chk(ras1 && cas1 && we1 && !busy1 && !req1 && !urg1 && !done1, "R1 u1 reset",
            {ras1, cas1, we1, busy1, req1, urg1, done1}, 7'b1110000);
        rst_n = 1'b1; g0 = 1'b1; g1 = 1'b1;
        @(negedge clk);
        chk(ras0 && cas0 && !busy0 && !req0, "R1 after release", {ras0, cas0, busy0, req0}, 4'b1100);
        repeat (PAUSE0 - 3) @(negedge clk);
        // R2: grant high yet nothing during the pause
        chk(!req0, "R2 req in pause", req0, 0);
        chk(falls0 == 0, "R2 strobes in pause", falls0, 0);
        n = 0;
        while (!done0 && n < 500) begin @(negedge clk); n++; end
        t_init = cyc;
        // R3: exact init cycle count at the rise of init_done
        chk(done0, "R3 init_done rises", done0, 1);
        chk(falls0 == INIT0, "R3 init cycles", falls0, INIT0);
        chk(!busy0 && !req0, "R3 idle after init", {busy0, req0}, 0);
        g0 = 1'b0;
        wait_req0(t_first);
        // R4: first refresh owed one interval after init_done
        chk(t_first - t_init == REFI0, "R4 first interval", t_first - t_init, REFI0);
        for (int i = 0; i < NVEC; i++) begin
            if (i > 0) begin
                wait_req0(t_rise);
                // R4: owed refreshes keep the interval phase
                chk((t_rise - t_first) % REFI0 == 0, "R4 interval phase",
                    (t_rise - t_first) % REFI0, 0);
            end
            snap_f = falls0;
            repeat ((VEC[i][0] - 1) * REFI0 + REFI0 / 2) @(negedge clk);
            // R5: urgent only at the saturation limit
            chk(urg0 == VEC[i][1], "R5 urgent flag", urg0, VEC[i][1]);
            chk(req0, "R4 req while owed", req0, 1);
            // R11: nothing strobed while grant is low
            chk(falls0 == snap_f, "R11 no strobes without grant", falls0 - snap_f, 0);
            snap_c = casr0;
            g0 = 1'b1;
            repeat (40) @(negedge clk);
            g0 = 1'b0;
            repeat (2) @(negedge clk);
            // R5: burst length equals the saturated owed count
            chk(falls0 - snap_f == VEC[i][2], "R5 burst length", falls0 - snap_f, VEC[i][2]);
            // R8: chained refreshes keep cas_n low, one rise per burst
            chk(casr0 - snap_c == 1, "R8 cas rises per burst", casr0 - snap_c, 1);
            chk(!req0 && !busy0, "R4 served", {req0, busy0}, 0);
        end
        n = 0;
        while (falls1 < 4100 && n < 100000) begin @(negedge clk); n++; end
        // R9: row-address instance
        chk(falls1 >= 4100, "R9 refresh count", falls1, 4100);
        chk(v_row1 == 0, "R9 row sequence", v_row1, 0);
        chk(wraps1 >= 1, "R9 row wrap", wraps1, 1);
        chk(v_cas1 == 0, "R9 cas held high", v_cas1, 0);
        // R6: strobe widths on both instances
        chk(v_ras0 == 0 && v_ras1 == 0, "R6 ras low width", v_ras0 + v_ras1, 0);
        chk(v_rp0 == 0 && v_rp1 == 0, "R6 precharge width", v_rp0 + v_rp1, 0);
        // R7: column-first lead and hold, address held at zero
        chk(v_lead0 == 0, "R7 cas lead", v_lead0, 0);
        chk(v_hold0 == 0, "R7 cas hold", v_hold0, 0);
        chk(v_row0 == 0, "R7 row_addr zero", v_row0, 0);
        // R10: write strobe never asserted
        chk(v_we == 0, "R10 we_n high", v_we, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule